// File: doc/BRIEF.md
# Three-Port Memory Request Arbiter

This block lets three independent masters share a single memory request port that takes a flat linear address. Each master pushes commands (a read or write flag plus an address) into a command queue of its own, and pushes write data into a separate write-data queue of its own. A round-robin picker looks at which command queues hold an entry and that can be served. It sends one command at a time to the shared downstream port. For each write it then streams the matching data beats from the same master's data queue.

Every read that is issued records the issuing master in an in-order tag queue. Read data returning from the memory side is steered to the master named at the head of that queue. Bank, row and column decoding, refresh and the physical layer lie outside the block. The downstream side is a plain valid/ready command channel, a valid/ready write-data channel and a valid-only read-return channel.

Top module: `mem_port_mux`

## Requirements
- R1: After reset all queues are empty: every `cmd_ready` and `wd_ready` bit is 1, and `mem_cmd_valid`, `mem_wd_valid` and all `rsp_valid` bits are 0. The round-robin pointer starts at master 0.
- R2: A master's `cmd_ready` is 0 exactly while its command queue holds CMD_DEPTH (default 4) entries. Its `wd_ready` is 0 exactly while its data queue holds DAT_DEPTH (default 8) beats.
- R3: When several masters are eligible, grants rotate in ascending master order, starting from the master after the last granted one and wrapping from 2 to 0.
- R4: Masters with nothing to send are skipped in the same cycle. A command entering an otherwise idle arbiter appears on `mem_cmd_valid` in the cycle after it is pushed.
- R5: A write (`cmd_we`=1) is not offered downstream until its master's data queue holds at least BEATS (default 2) beats. Meanwhile other eligible masters are served.
- R6: Once `mem_cmd_valid` is 1, it stays 1 with unchanged `mem_cmd_we` and `mem_cmd_addr` until `mem_cmd_ready` is 1. A queue entry is removed only on that handshake.
- R7: After a write is accepted, exactly BEATS beats from that master's data queue follow on the write-data channel, in push order. `mem_wd_last` is 1 on the final beat, and no command is offered while they are in flight.
- R8: Read-return beats are presented on the `rsp_valid` bit of the master that issued the oldest outstanding read. The data and last flag pass through unchanged, and that read retires when a beat with `mem_rd_last`=1 arrives.
- R9: `mem_cmd_addr` carries the master's address unchanged (flat address, no decomposition).
- R10: While TAG_DEPTH (default 4) reads are outstanding, no further read is issued. Writes still are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | NP | Per-master command push strobe |
| cmd_ready | output | NP | Per-master command queue has room |
| cmd_we | input | NP | Per-master command type, 1 = write |
| cmd_addr | input | NP*AW | Per-master flat address, master p in bits p*AW +: AW |
| wd_valid | input | NP | Per-master write-data push strobe |
| wd_ready | output | NP | Per-master data queue has room |
| wd_data | input | NP*DW | Per-master write beat, master p in bits p*DW +: DW |
| rsp_valid | output | NP | Read beat belongs to this master (one-hot or zero) |
| rsp_data | output | DW | Read beat data |
| rsp_last | output | 1 | Final beat of a read |
| mem_cmd_valid | output | 1 | Downstream command offered |
| mem_cmd_ready | input | 1 | Downstream accepts command |
| mem_cmd_we | output | 1 | Downstream command type, 1 = write |
| mem_cmd_addr | output | AW | Downstream flat address |
| mem_wd_valid | output | 1 | Downstream write beat offered |
| mem_wd_ready | input | 1 | Downstream accepts write beat |
| mem_wd_data | output | DW | Downstream write beat |
| mem_wd_last | output | 1 | Final beat of the current write |
| mem_rd_valid | input | 1 | Read beat returning |
| mem_rd_data | input | DW | Returned read data |
| mem_rd_last | input | 1 | Final returned beat of a read |

## Verification
The hardest case to reach is a write that sits at the head of its queue without enough data while another master keeps being served. The stimulus creates it by pushing a single data beat and then the write command. A read from a different master follows, and the bench confirms that only the read leaves. The second beat is pushed only after that. Tag-queue exhaustion is reached by issuing four reads that are never answered, then pushing a fifth read and a write behind them.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  typedef enum logic [0:0] {
    ST_ARB   = 1'b0,
    ST_WDATA = 1'b1
  } mpa_state_e;
endpackage

// File: rtl/mpa_fifo.sv
module mpa_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH-1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (push) wr_d = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
    if (push && !pop)      lvl_d = lvl_q + 1'b1;
    else if (pop && !push) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= din;
  end

  assign dout  = store[rd_q];
  assign level = lvl_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (lvl_q != FULL_LVL)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (lvl_q != '0)); // R6
endmodule

// File: rtl/mpa_rr_pick.sv
module mpa_rr_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    int c;
    any = 1'b0;
    idx = ptr;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!any && req[c]) begin
        any = 1'b1;
        idx = IW'(c);
      end
    end
  end
endmodule

// File: rtl/mem_port_mux.sv
module mem_port_mux
  import mpa_pkg::*;
#(
  parameter int NP        = 3,
  parameter int AW        = 24,
  parameter int DW        = 32,
  parameter int BEATS     = 2,
  parameter int CMD_DEPTH = 4,
  parameter int DAT_DEPTH = 8,
  parameter int TAG_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    cmd_valid,
  output logic [NP-1:0]    cmd_ready,
  input  logic [NP-1:0]    cmd_we,
  input  logic [NP*AW-1:0] cmd_addr,
  input  logic [NP-1:0]    wd_valid,
  output logic [NP-1:0]    wd_ready,
  input  logic [NP*DW-1:0] wd_data,
  output logic [NP-1:0]    rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_last,
  output logic             mem_cmd_valid,
  input  logic             mem_cmd_ready,
  output logic             mem_cmd_we,
  output logic [AW-1:0]    mem_cmd_addr,
  output logic             mem_wd_valid,
  input  logic             mem_wd_ready,
  output logic [DW-1:0]    mem_wd_data,
  output logic             mem_wd_last,
  input  logic             mem_rd_valid,
  input  logic [DW-1:0]    mem_rd_data,
  input  logic             mem_rd_last
);
  localparam int IW  = (NP > 1) ? $clog2(NP) : 1;
  localparam int CLW = $clog2(CMD_DEPTH+1);
  localparam int DLW = $clog2(DAT_DEPTH+1);
  localparam int TLW = $clog2(TAG_DEPTH+1);
  localparam int BW  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CLW-1:0] CMD_FULL  = CLW'(CMD_DEPTH);
  localparam logic [DLW-1:0] DAT_FULL  = DLW'(DAT_DEPTH);
  localparam logic [TLW-1:0] TAG_FULL  = TLW'(TAG_DEPTH);
  localparam logic [DLW-1:0] BEATS_C   = DLW'(BEATS);
  localparam logic [BW-1:0]  LAST_BEAT = BW'(BEATS-1);
  localparam logic [IW-1:0]  LAST_P    = IW'(NP-1);

  logic [NP-1:0][AW:0]     cmd_head;
  logic [NP-1:0][CLW-1:0]  cmd_lvl;
  logic [NP-1:0][DW-1:0]   dat_head;
  logic [NP-1:0][DLW-1:0]  dat_lvl;
  logic [NP-1:0]           cmd_push, cmd_pop, dat_push, dat_pop, elig;
  logic [IW-1:0]           tag_head;
  logic [TLW-1:0]          tag_lvl;
  logic                    tag_full, tag_empty, tag_push, tag_pop;

  mpa_state_e    st_q, st_d;
  logic [BW-1:0] beat_q, beat_d;
  logic [IW-1:0] wport_q, wport_d, hold_port_q, hold_port_d, ptr_q, ptr_d;
  logic          hold_q, hold_d;
  logic          pick_any, accept;
  logic [IW-1:0] pick_idx, grant;
  logic [DLW-1:0] grant_lvl;

  // Per-master command and write-data queues
  for (genvar p = 0; p < NP; p++) begin : g_port
    assign cmd_ready[p] = (cmd_lvl[p] != CMD_FULL);
    assign wd_ready[p]  = (dat_lvl[p] != DAT_FULL);
    assign cmd_push[p]  = cmd_valid[p] && cmd_ready[p];
    assign dat_push[p]  = wd_valid[p] && wd_ready[p];
    assign cmd_pop[p]   = accept && (grant == IW'(p));
    assign dat_pop[p]   = (st_q == ST_WDATA) && mem_wd_ready && (wport_q == IW'(p));
    assign elig[p]      = (st_q == ST_ARB) && (cmd_lvl[p] != '0) &&
                          (cmd_head[p][AW] ? (dat_lvl[p] >= BEATS_C) : !tag_full);
    assign rsp_valid[p] = mem_rd_valid && !tag_empty && (tag_head == IW'(p));

    mpa_fifo #(.W(AW+1), .DEPTH(CMD_DEPTH)) i_cmd_q (
      .clk(clk), .rst_n(rst_n), .push(cmd_push[p]),
      .din({cmd_we[p], cmd_addr[p*AW +: AW]}), .pop(cmd_pop[p]),
      .dout(cmd_head[p]), .level(cmd_lvl[p]));

    mpa_fifo #(.W(DW), .DEPTH(DAT_DEPTH)) i_dat_q (
      .clk(clk), .rst_n(rst_n), .push(dat_push[p]),
      .din(wd_data[p*DW +: DW]), .pop(dat_pop[p]),
      .dout(dat_head[p]), .level(dat_lvl[p]));
  end

  // In-order read tag queue
  assign tag_full  = (tag_lvl == TAG_FULL);
  assign tag_empty = (tag_lvl == '0);
  assign tag_push  = accept && !mem_cmd_we;
  assign tag_pop   = mem_rd_valid && mem_rd_last && !tag_empty;

  mpa_fifo #(.W(IW), .DEPTH(TAG_DEPTH)) i_tag_q (
    .clk(clk), .rst_n(rst_n), .push(tag_push), .din(grant),
    .pop(tag_pop), .dout(tag_head), .level(tag_lvl));

  mpa_rr_pick #(.N(NP), .IW(IW)) i_pick (
    .req(elig), .ptr(ptr_q), .any(pick_any), .idx(pick_idx));

  assign grant         = hold_q ? hold_port_q : pick_idx;
  assign mem_cmd_valid = (st_q == ST_ARB) && (hold_q || pick_any);
  assign accept        = mem_cmd_valid && mem_cmd_ready;
  assign mem_wd_valid  = (st_q == ST_WDATA);
  assign mem_wd_last   = mem_wd_valid && (beat_q == LAST_BEAT);
  assign rsp_data      = mem_rd_data;
  assign rsp_last      = mem_rd_last;

  always_comb begin
    mem_cmd_we   = 1'b0;
    mem_cmd_addr = '0;
    mem_wd_data  = '0;
    grant_lvl    = '0;
    for (int p = 0; p < NP; p++) begin
      if (grant == IW'(p)) begin
        mem_cmd_we   = cmd_head[p][AW];
        mem_cmd_addr = cmd_head[p][AW-1:0];
        grant_lvl    = dat_lvl[p];
      end
      if (wport_q == IW'(p)) mem_wd_data = dat_head[p];
    end
  end

  // Next-state logic
  always_comb begin
    st_d        = st_q;
    beat_d      = beat_q;
    wport_d     = wport_q;
    ptr_d       = ptr_q;
    hold_d      = mem_cmd_valid && !mem_cmd_ready;
    hold_port_d = hold_d ? grant : hold_port_q;
    case (st_q)
      ST_ARB: begin
        if (accept) begin
          ptr_d = (grant == LAST_P) ? '0 : grant + 1'b1;
          if (mem_cmd_we) begin
            st_d    = ST_WDATA;
            wport_d = grant;
            beat_d  = '0;
          end
        end
      end
      ST_WDATA: begin
        if (mem_wd_ready) begin
          if (beat_q == LAST_BEAT) begin
            st_d   = ST_ARB;
            beat_d = '0;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      default: st_d = ST_ARB;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_ARB;
      beat_q      <= '0;
      wport_q     <= '0;
      ptr_q       <= '0;
      hold_q      <= 1'b0;
      hold_port_q <= '0;
    end else begin
      st_q        <= st_d;
      beat_q      <= beat_d;
      wport_q     <= wport_d;
      ptr_q       <= ptr_d;
      hold_q      <= hold_d;
      hold_port_q <= hold_port_d;
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_we))); // R6
  AST_WR_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_we) |-> (grant_lvl >= BEATS_C)); // R5
  AST_NO_CMD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wd_valid |-> !mem_cmd_valid); // R7
  AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid)); // R8
  AST_RD_HAS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !tag_empty); // R8
  AST_TAG_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_we) |-> !tag_full); // R10
endmodule

// File: tb/test_mem_port_mux.sv
module test_mem_port_mux;
  localparam int NP = 3, AW = 24, DW = 32, BEATS = 2;

  logic clk, rst_n;
  logic [NP-1:0] cmd_valid, cmd_ready, cmd_we, wd_valid, wd_ready, rsp_valid;
  logic [NP*AW-1:0] cmd_addr;
  logic [NP*DW-1:0] wd_data;
  logic [DW-1:0] rsp_data, mem_wd_data, mem_rd_data;
  logic rsp_last, mem_cmd_valid, mem_cmd_ready, mem_cmd_we;
  logic [AW-1:0] mem_cmd_addr;
  logic mem_wd_valid, mem_wd_ready, mem_wd_last, mem_rd_valid, mem_rd_last;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [AW-1:0] c_addr [64];
  logic          c_we   [64];
  logic [DW-1:0] w_data [64];
  logic          w_last [64];
  int            r_port [64];
  logic [DW-1:0] r_data [64];
  logic          r_last [64];
  int nc = 0, nw = 0, nr = 0;

  mem_port_mux i_mem_port_mux (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_we(mem_cmd_we),
    .mem_cmd_addr(mem_cmd_addr), .mem_wd_valid(mem_wd_valid), .mem_wd_ready(mem_wd_ready),
    .mem_wd_data(mem_wd_data), .mem_wd_last(mem_wd_last), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_rd_last(mem_rd_last));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Handshake monitor, sampling mid low phase
  always begin
    @(negedge clk); #5;
    if (rst_n) begin
      if (mem_cmd_valid && mem_cmd_ready && nc < 64) begin
        c_addr[nc] = mem_cmd_addr; c_we[nc] = mem_cmd_we; nc++;
      end
      if (mem_wd_valid && mem_wd_ready && nw < 64) begin
        w_data[nw] = mem_wd_data; w_last[nw] = mem_wd_last; nw++;
      end
      if (rsp_valid != '0 && nr < 64) begin
        r_port[nr] = -1;
        for (int p = 0; p < NP; p++) if (rsp_valid[p]) r_port[nr] = p;
        r_data[nr] = rsp_data; r_last[nr] = rsp_last; nr++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rdat(input logic [AW-1:0] a, input int b);
    return {a, 8'(b)};
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_cmd(input int p, input logic we, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_valid[p] = 1'b1; cmd_we[p] = we; cmd_addr[p*AW +: AW] = a;
    #5;
    while (!cmd_ready[p]) begin @(negedge clk); #5; end
    @(negedge clk);
    cmd_valid[p] = 1'b0;
  endtask

  task automatic push_wd(input int p, input logic [DW-1:0] d);
    @(negedge clk);
    wd_valid[p] = 1'b1; wd_data[p*DW +: DW] = d;
    #5;
    while (!wd_ready[p]) begin @(negedge clk); #5; end
    @(negedge clk);
    wd_valid[p] = 1'b0;
  endtask

  task automatic return_read(input logic [AW-1:0] a);
    for (int b = 0; b < BEATS; b++) begin
      @(negedge clk);
      mem_rd_valid = 1'b1; mem_rd_data = rdat(a, b); mem_rd_last = (b == BEATS-1);
    end
    @(negedge clk);
    mem_rd_valid = 1'b0; mem_rd_last = 1'b0;
  endtask

  // Check NEXP read beats starting at log index base for address a
  task automatic check_rsp(input int base, input logic [AW-1:0] a, input string req);
    for (int b = 0; b < BEATS; b++) begin
      chk(r_port[base+b] == int'(a >> 16), req, r_port[base+b], a >> 16);
      chk(r_data[base+b] == rdat(a, b), req, r_data[base+b], rdat(a, b));
      chk(r_last[base+b] == (b == BEATS-1), req, r_last[base+b], b == BEATS-1);
    end
  endtask

  task automatic test_reset();
    #5;
    chk(cmd_ready == '1, "R1 cmd_ready", cmd_ready, 3'b111);
    chk(wd_ready == '1, "R1 wd_ready", wd_ready, 3'b111);
    chk(!mem_cmd_valid && !mem_wd_valid, "R1 mem valids", {mem_cmd_valid, mem_wd_valid}, 0);
    chk(rsp_valid == '0, "R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic test_full_and_rotation();
    logic [AW-1:0] exp_a [8];
    int c0, w0, r0;
    c0 = nc; w0 = nw;
    mem_cmd_ready = 1'b0;
    push_cmd(0, 1'b0, 24'h000000);
    push_cmd(0, 1'b0, 24'h000001);
    push_cmd(2, 1'b0, 24'h020000);
    push_cmd(2, 1'b0, 24'h020001);
    for (int k = 0; k < 8; k++) push_wd(1, 32'hD1000000 + k);
    for (int k = 0; k < 4; k++) push_cmd(1, 1'b1, 24'h010000 + k);
    #5;
    chk(cmd_ready == 3'b101, "R2 cmd queue full", cmd_ready, 3'b101);
    chk(wd_ready == 3'b101, "R2 data queue full", wd_ready, 3'b101);
    @(negedge clk);
    mem_cmd_ready = 1'b1; mem_wd_ready = 1'b1;
    cycles(30);
    exp_a = '{24'h000000, 24'h010000, 24'h020000, 24'h000001,
              24'h010001, 24'h020001, 24'h010002, 24'h010003};
    chk(nc - c0 == 8, "R3 command count", nc - c0, 8);
    for (int k = 0; k < 8; k++) begin
      chk(c_addr[c0+k] == exp_a[k], "R3 R9 grant order/address", c_addr[c0+k], exp_a[k]);
      chk(c_we[c0+k] == (exp_a[k][16] == 1'b1), "R3 command type", c_we[c0+k], exp_a[k][16]);
    end
    chk(nw - w0 == 8, "R7 beat count", nw - w0, 8);
    for (int k = 0; k < 8; k++) begin
      chk(w_data[w0+k] == 32'hD1000000 + k, "R7 beat data", w_data[w0+k], 32'hD1000000 + k);
      chk(w_last[w0+k] == k[0], "R7 last flag", w_last[w0+k], k[0]);
    end
    chk(cmd_ready == '1 && wd_ready == '1, "R2 ready restored", {cmd_ready, wd_ready}, 6'h3f);
    r0 = nr;
    return_read(24'h000000);
    return_read(24'h020000);
    return_read(24'h000001);
    return_read(24'h020001);
    cycles(1);
    chk(nr - r0 == 4*BEATS, "R8 beat count", nr - r0, 4*BEATS);
    check_rsp(r0,             24'h000000, "R8 route");
    check_rsp(r0 + BEATS,     24'h020000, "R8 route");
    check_rsp(r0 + 2*BEATS,   24'h000001, "R8 route");
    check_rsp(r0 + 3*BEATS,   24'h020001, "R8 route");
  endtask

  task automatic test_skip_and_hold();
    int c0, r0;
    c0 = nc;
    mem_cmd_ready = 1'b0;
    push_cmd(1, 1'b0, 24'h010005);
    #5;
    chk(mem_cmd_valid == 1'b1, "R4 offered next cycle", mem_cmd_valid, 1);
    chk(mem_cmd_addr == 24'h010005, "R4 R9 address", mem_cmd_addr, 24'h010005);
    cycles(3); #5;
    chk(mem_cmd_valid == 1'b1, "R6 valid held", mem_cmd_valid, 1);
    chk(mem_cmd_addr == 24'h010005 && !mem_cmd_we, "R6 contents held", mem_cmd_addr, 24'h010005);
    chk(nc == c0, "R6 no transfer while stalled", nc - c0, 0);
    @(negedge clk);
    mem_cmd_ready = 1'b1;
    cycles(2); #5;
    chk(nc - c0 == 1, "R6 exactly one transfer", nc - c0, 1);
    chk(mem_cmd_valid == 1'b0, "R6 entry removed", mem_cmd_valid, 0);
    r0 = nr;
    return_read(24'h010005);
    cycles(1);
    check_rsp(r0, 24'h010005, "R8 route to master 1");
  endtask

  task automatic test_write_waits();
    int c0, w0, r0;
    c0 = nc; w0 = nw;
    push_wd(2, 32'hD2000000);
    push_cmd(2, 1'b1, 24'h020010);
    push_cmd(0, 1'b0, 24'h000011);
    cycles(6);
    chk(nc - c0 == 1, "R5 only read issued", nc - c0, 1);
    chk(c_addr[c0] == 24'h000011 && !c_we[c0], "R5 other master served", c_addr[c0], 24'h000011);
    chk(nw == w0, "R5 no beat sent", nw - w0, 0);
    push_wd(2, 32'hD2000001);
    cycles(6);
    chk(nc - c0 == 2, "R5 write issued after data", nc - c0, 2);
    chk(c_addr[c0+1] == 24'h020010 && c_we[c0+1], "R5 write address", c_addr[c0+1], 24'h020010);
    chk(nw - w0 == 2, "R7 two beats", nw - w0, 2);
    chk(w_data[w0] == 32'hD2000000 && w_data[w0+1] == 32'hD2000001,
        "R7 beat order", w_data[w0], 32'hD2000000);
    r0 = nr;
    return_read(24'h000011);
    cycles(1);
    check_rsp(r0, 24'h000011, "R8 route to master 0");
  endtask

  task automatic test_tag_limit();
    int c0, r0;
    c0 = nc;
    for (int k = 0; k < 4; k++) push_cmd(0, 1'b0, 24'h000020 + k);
    push_cmd(0, 1'b0, 24'h000024);
    cycles(4); #5;
    chk(nc - c0 == 4, "R10 four reads out", nc - c0, 4);
    chk(mem_cmd_valid == 1'b0, "R10 fifth read held", mem_cmd_valid, 0);
    push_wd(1, 32'hD1000100);
    push_wd(1, 32'hD1000101);
    push_cmd(1, 1'b1, 24'h010030);
    cycles(5);
    chk(nc - c0 == 5 && c_addr[c0+4] == 24'h010030, "R10 write passes", c_addr[c0+4], 24'h010030);
    r0 = nr;
    return_read(24'h000020);
    cycles(3);
    chk(nc - c0 == 6 && c_addr[c0+5] == 24'h000024, "R10 read after retire", c_addr[c0+5], 24'h000024);
    for (int k = 1; k < 5; k++) return_read(24'h000020 + k);
    cycles(1);
    for (int k = 0; k < 5; k++) check_rsp(r0 + k*BEATS, 24'h000020 + k, "R8 in-order return");
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_valid = '0; cmd_we = '0; cmd_addr = '0; wd_valid = '0; wd_data = '0;
    mem_cmd_ready = 1'b0; mem_wd_ready = 1'b1;
    mem_rd_valid = 1'b0; mem_rd_data = '0; mem_rd_last = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    test_reset();
    test_full_and_rotation();
    test_skip_and_hold();
    test_write_waits();
    test_tag_limit();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule